// File: doc/BRIEF.md
# Command Ring Consumer with Completion Fences

This block sits on the device side of a circular command queue kept in memory. The host writes 32-bit packet words into the ring, then tells the device how far it has written by posting a new write index through a plain register port. The block compares that index with its own read index. While the two differ, it reads words in order through a simple memory read port and decodes each packet header.

Command packets are a header followed by the number of payload words the header declares. The header and every payload word leave through a valid/ready stream. The downstream side may hold `cmd_ready` low for as long as it likes. While it does, the word on `cmd_data` and its `cmd_last` flag stay frozen, and no further ring entries are consumed beyond the one parked at the memory port. A word transfers on each rising edge where `cmd_valid` and `cmd_ready` are both high.

Fence packets are a header and one value word. They are not forwarded. Their value is copied into a host-visible completion register, together with a one-cycle interrupt pulse. The read index the host can see is not updated on every word. It advances in batches of a parameterised size, and it is also brought up to date early whenever a fence completes or the ring drains.

Top module: `cmd_ring_consumer`

## Requirements
- R1: After reset, `rp_report`, `fence_value`, `fence_irq`, `err_flag`, `cmd_valid` and `mem_rd_en` are all zero.
- R2: While the posted write index equals the internal read index, no memory read is issued. The write index changes only through `wp_wr_en`.
- R3: A header whose type bits [31:30] are 2'b00 is forwarded, followed by exactly N payload words, where N is header bits [15:0]. Words leave in ring order. `cmd_last` is high on the final word of each packet, which is the header itself when N is 0.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_last` hold their values.
- R5: `rp_report` moves to the current consumed position each time another BATCH words (default 4) have been consumed since its last update.
- R6: When consuming a word empties the ring, `rp_report` is set to that position, even if the batch is only partly filled.
- R7: A fence packet is a header with type 2'b01 followed by one value word. The value is written to `fence_value` only after every earlier command word has been accepted downstream. Fence words are never forwarded.
- R8: Each fence update raises `fence_irq` for exactly one cycle, on the same edge where `fence_value` changes.
- R9: A header with type 2'b10 or 2'b11 sets the sticky `err_flag`. Only that header word is dropped, and the following packet is processed normally.
- R10: Indices wrap modulo the ring size, which is 2**IDX_W (default 16) entries. Packets that cross the end of the ring are handled without any break in the stream.
- R11: Completing a fence updates `rp_report` to the position just after the fence value word, even when the batch is partly filled and the ring is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_wr_en | input | 1 | Host posts a new write index |
| wp_wr_data | input | IDX_W | Write index value (one past the last word written) |
| mem_rd_en | output | 1 | Ring read request |
| mem_rd_addr | output | IDX_W | Ring entry to read |
| mem_rd_data | input | 32 | Read data, valid from the cycle after `mem_rd_en` and held until the next request |
| cmd_valid | output | 1 | Forwarded command word available |
| cmd_ready | input | 1 | Downstream accepts the word |
| cmd_data | output | 32 | Forwarded command word |
| cmd_last | output | 1 | Final word of a command packet |
| rp_report | output | IDX_W | Host-visible read index |
| fence_value | output | 32 | Last completed fence value |
| fence_irq | output | 1 | One-cycle pulse per fence update |
| err_flag | output | 1 | Sticky flag for a reserved packet type |

## Verification
Two update causes for the host-visible read index can land on the same edge. In one scenario the fence value word is also the fourth word of a batch, and it is also the last word in the ring. That edge must produce one clean update to the final position, not a double step or a lost one. A second scenario separates the causes: a fence completes while a later command is still parked behind a stalled downstream. The bench then expects `rp_report` to stop at the fence and not jump to the batch or drain positions. A further scenario holds `cmd_ready` low so that a fence sits behind an unaccepted command word, and judges that `fence_value` and the interrupt stay quiet until the release.

// File: rtl/crc_pkg.sv
package crc_pkg;

  // packet type field sits in the top two header bits
  localparam int TYPE_HI = 31;
  localparam int TYPE_LO = 30;

  typedef enum logic [1:0] {
    PK_CMD   = 2'b00,
    PK_FENCE = 2'b01
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_BODY = 2'd1,
    ST_FVAL = 2'd2
  } dec_state_e;

endpackage

// File: rtl/crc_ptr_track.sv
module crc_ptr_track #(
  parameter int IDX_W = 4,
  parameter int BATCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_wr_en,
  input  logic [IDX_W-1:0] wp_wr_data,
  input  logic             take,
  input  logic             fence_flush,
  output logic [IDX_W-1:0] wp_q,
  output logic [IDX_W-1:0] rp_next,
  output logic [IDX_W-1:0] rp_report
);

  localparam int CNT_W = $clog2(BATCH + 1);

  logic [IDX_W-1:0] rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             batch_full;
  logic             drained;
  logic             publish;

  assign rp_next    = rp_q + IDX_W'(take);
  assign batch_full = (cnt_q == CNT_W'(BATCH - 1));
  assign drained    = (rp_next == wp_q);
  assign publish    = take && (batch_full || fence_flush || drained);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0;
    end else if (wp_wr_en) begin
      wp_q <= wp_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_q      <= '0;
      cnt_q     <= '0;
      rp_report <= '0;
    end else if (take) begin
      rp_q <= rp_next;
      if (publish) begin
        rp_report <= rp_next;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/crc_fetch.sv
module crc_fetch #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rp_next,
  input  logic [IDX_W-1:0] wp_q,
  input  logic             take,
  output logic             mem_rd_en,
  output logic [IDX_W-1:0] mem_rd_addr,
  output logic             word_valid
);

  logic pend_q;

  // a new read may start when no word is parked or the parked one leaves now
  assign mem_rd_en   = (!pend_q || take) && (rp_next != wp_q);
  assign mem_rd_addr = rp_next;
  assign word_valid  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (mem_rd_en) begin
      pend_q <= 1'b1;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/crc_decode.sv
module crc_decode
  import crc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              cmd_ready,
  output logic              take,
  output logic              fence_flush,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_last,
  output logic [DATA_W-1:0] fence_value,
  output logic              fence_irq,
  output logic              err_flag
);

  dec_state_e       st_q, st_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             out_free;
  logic             load;
  logic             load_last;
  logic             fence_wr;
  logic             err_set;
  logic [1:0]       kind;
  logic [LEN_W-1:0] hdr_len;

  assign out_free = !cmd_valid || cmd_ready;
  assign kind     = word_data[TYPE_HI:TYPE_LO];
  assign hdr_len  = word_data[LEN_W-1:0];

  always_comb begin
    st_d      = st_q;
    left_d    = left_q;
    take      = 1'b0;
    load      = 1'b0;
    load_last = 1'b0;
    fence_wr  = 1'b0;
    err_set   = 1'b0;
    unique case (st_q)
      ST_HDR: begin
        if (word_valid) begin
          if (kind == PK_CMD) begin
            if (out_free) begin
              take      = 1'b1;
              load      = 1'b1;
              load_last = (hdr_len == '0);
              left_d    = hdr_len;
              if (hdr_len != '0) st_d = ST_BODY;
            end
          end else if (kind == PK_FENCE) begin
            take = 1'b1;
            st_d = ST_FVAL;
          end else begin
            take    = 1'b1;
            err_set = 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (word_valid && out_free) begin
          take      = 1'b1;
          load      = 1'b1;
          load_last = (left_q == LEN_W'(1));
          left_d    = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) st_d = ST_HDR;
        end
      end
      ST_FVAL: begin
        // all earlier command words must have left the output register
        if (word_valid && !cmd_valid) begin
          take     = 1'b1;
          fence_wr = 1'b1;
          st_d     = ST_HDR;
        end
      end
      default: st_d = ST_HDR;
    endcase
  end

  assign fence_flush = fence_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_last  <= 1'b0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_data  <= word_data;
      cmd_last  <= load_last;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fence_value <= '0;
      fence_irq   <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      fence_irq <= fence_wr;
      if (fence_wr) fence_value <= word_data;
      if (err_set) err_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer #(
  parameter int IDX_W  = 4,
  parameter int BATCH  = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_wr_en,
  input  logic [IDX_W-1:0]  wp_wr_data,
  output logic              mem_rd_en,
  output logic [IDX_W-1:0]  mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_last,
  output logic [IDX_W-1:0]  rp_report,
  output logic [DATA_W-1:0] fence_value,
  output logic              fence_irq,
  output logic              err_flag
);

  logic [IDX_W-1:0] wp_q;
  logic [IDX_W-1:0] rp_next;
  logic             take;
  logic             fence_flush;
  logic             word_valid;

  crc_ptr_track #(.IDX_W(IDX_W), .BATCH(BATCH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_wr_en    (wp_wr_en),
    .wp_wr_data  (wp_wr_data),
    .take        (take),
    .fence_flush (fence_flush),
    .wp_q        (wp_q),
    .rp_next     (rp_next),
    .rp_report   (rp_report)
  );

  crc_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .rp_next     (rp_next),
    .wp_q        (wp_q),
    .take        (take),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .word_valid  (word_valid)
  );

  crc_decode #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_data   (mem_rd_data),
    .cmd_ready   (cmd_ready),
    .take        (take),
    .fence_flush (fence_flush),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .cmd_last    (cmd_last),
    .fence_value (fence_value),
    .fence_irq   (fence_irq),
    .err_flag    (err_flag)
  );

endmodule

// File: rtl/cmd_ring_consumer_chk.sv
module cmd_ring_consumer_chk #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] fence_value,
  input logic              fence_irq,
  input logic              err_flag,
  input logic              mem_rd_en,
  input logic [IDX_W-1:0]  mem_rd_addr,
  input logic [IDX_W-1:0]  wp_q
);

  // R2
  no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr != wp_q));

  // R4
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R7
  fence_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_irq |-> !cmd_valid);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_irq |=> !fence_irq);

  // R8
  value_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_irq |-> $stable(fence_value));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

bind cmd_ring_consumer cmd_ring_consumer_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_data    (cmd_data),
  .fence_value (fence_value),
  .fence_irq   (fence_irq),
  .err_flag    (err_flag),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .wp_q        (wp_q)
);

// File: tb/sim_cmd_ring_consumer.sv
`timescale 1ns/1ps
module sim_cmd_ring_consumer;

  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wp_wr_en = 1'b0;
  logic [IDX_W-1:0] wp_wr_data = '0;
  logic             mem_rd_en;
  logic [IDX_W-1:0] mem_rd_addr;
  logic [31:0]      mem_rd_data = '0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b1;
  logic [31:0]      cmd_data;
  logic             cmd_last;
  logic [IDX_W-1:0] rp_report;
  logic [31:0]      fence_value;
  logic             fence_irq;
  logic             err_flag;

  int tests = 0;
  int fails = 0;
  int irq_seen = 0;
  int rd_seen = 0;

  logic [31:0]      ring [DEPTH];
  logic [IDX_W-1:0] hwp = '0;
  logic [32:0]      exp_q[$];
  logic [32:0]      got_q[$];

  always #4 clk = ~clk;

  cmd_ring_consumer u0 (
    .clk(clk), .rst_n(rst_n), .wp_wr_en(wp_wr_en), .wp_wr_data(wp_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .rp_report(rp_report), .fence_value(fence_value),
    .fence_irq(fence_irq), .err_flag(err_flag)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= ring[mem_rd_addr];
      rd_seen <= rd_seen + 1;
    end
    if (rst_n && cmd_valid && cmd_ready) got_q.push_back({cmd_last, cmd_data});
    if (rst_n && fence_irq) irq_seen <= irq_seen + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w, input logic fwd, input logic last);
    ring[hwp] = w;
    hwp = hwp + 1'b1;
    if (fwd) exp_q.push_back({last, w});
  endtask

  task automatic post();
    @(negedge clk);
    wp_wr_en = 1'b1;
    wp_wr_data = hwp;
    @(negedge clk);
    wp_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare_stream(input string req);
    check({req, " word count"}, 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check({req, " word"}, 64'(got_q[i]), 64'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    check("R1 rp_report", 64'(rp_report), 64'h0);
    check("R1 fence_value", 64'(fence_value), 64'h0);
    check("R1 irq", 64'(fence_irq), 64'h0);
    check("R1 err", 64'(err_flag), 64'h0);
    check("R1 cmd_valid", 64'(cmd_valid), 64'h0);
    check("R1 rd_en", 64'(mem_rd_en), 64'h0);
  endtask

  task automatic t_stall();
    // ring filled but write index not posted: nothing may be read (R2)
    ring[0] = 32'h0000_0000;
    idle(20);
    check("R2 no reads while empty", 64'(rd_seen), 64'h0);
  endtask

  task automatic t_cmd();
    put(32'h0000_0002, 1'b1, 1'b0);
    put(32'hA000_0001, 1'b1, 1'b0);
    put(32'hA000_0002, 1'b1, 1'b1);
    put(32'h0000_0000, 1'b1, 1'b1);
    put(32'h0000_0000, 1'b1, 1'b1);
    post();
    idle(20);
    compare_stream("R3");
    check("R6 drain flush", 64'(rp_report), 64'd5);
  endtask

  task automatic t_batch();
    logic [31:0] held;
    int consumed;
    int expr;
    cmd_ready = 1'b0;
    put(32'h0000_0009, 1'b1, 1'b0);
    for (int i = 1; i <= 9; i++) put(32'hB000_0000 | 32'(i), 1'b1, i == 9);
    post();
    idle(10);
    check("R5 no early report", 64'(rp_report), 64'd5);
    check("R4 valid held", 64'(cmd_valid), 64'h1);
    held = cmd_data;
    idle(5);
    check("R4 data held", 64'(cmd_data), 64'(held));
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      idle(3);
      consumed = (k + 1 > 10) ? 10 : k + 1;
      expr = (consumed == 10) ? 15 : 5 + 4 * (consumed / 4);
      check("R5 batch report", 64'(rp_report), 64'(expr));
    end
    cmd_ready = 1'b1;
    idle(3);
    compare_stream("R3 batch");
  endtask

  task automatic t_fence();
    // packet wraps the ring end (R10)
    cmd_ready = 1'b0;
    put(32'h0000_0001, 1'b1, 1'b0);
    put(32'hC000_00AA, 1'b1, 1'b1);
    put(32'h4000_0000, 1'b0, 1'b0);
    put(32'hCAFE_0001, 1'b0, 1'b0);
    post();
    idle(15);
    check("R7 fence waits", 64'(fence_value), 64'h0);
    check("R8 no irq yet", 64'(irq_seen), 64'h0);
    cmd_ready = 1'b1;
    idle(15);
    check("R7 fence value", 64'(fence_value), 64'hCAFE_0001);
    check("R8 one irq", 64'(irq_seen), 64'd1);
    check("R10 wrapped report", 64'(rp_report), 64'd3);
    compare_stream("R10 stream");
  endtask

  task automatic t_fence_flush();
    cmd_ready = 1'b0;
    put(32'h4000_0000, 1'b0, 1'b0);
    put(32'h1234_5678, 1'b0, 1'b0);
    put(32'h0000_0002, 1'b1, 1'b0);
    put(32'hD000_0001, 1'b1, 1'b0);
    put(32'hD000_0002, 1'b1, 1'b1);
    post();
    idle(15);
    check("R11 fence flush", 64'(rp_report), 64'd5);
    check("R7 value", 64'(fence_value), 64'h1234_5678);
    check("R8 irq count", 64'(irq_seen), 64'd2);
    cmd_ready = 1'b1;
    idle(15);
    check("R6 final drain", 64'(rp_report), 64'd8);
    compare_stream("R3 after fence");
  endtask

  task automatic t_reserved();
    put(32'h8000_0000, 1'b0, 1'b0);
    put(32'hC000_0000, 1'b0, 1'b0);
    put(32'h0000_0000, 1'b1, 1'b1);
    post();
    idle(15);
    check("R9 err set", 64'(err_flag), 64'h1);
    check("R9 report", 64'(rp_report), 64'd11);
    compare_stream("R9 skip");
    put(32'h0000_0000, 1'b1, 1'b1);
    post();
    idle(10);
    check("R9 err sticky", 64'(err_flag), 64'h1);
    compare_stream("R9 next");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ring[i] = '0;
    idle(4);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_stall();
    t_cmd();
    t_batch();
    t_fence();
    t_fence_flush();
    t_reserved();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule